// File: doc/BRIEF.md
# Buffered UART Transmitter

A serial transmit channel with one holding register in front of a shift register, programmed through a small register port of two address bits. Software sets a bit-period constant and a control byte, then writes data bytes. A byte written into the holding register moves into the shift register as soon as the shifter is idle. The byte then goes out on `txd` as an asynchronous frame: a low start bit, eight data bits least significant first, an optional parity bit, and a high stop bit.

A status register reports two flags. One shows that the holding register can take a byte. The other shows that both the holding register and the shifter have drained. The interrupt request stays high while the channel is enabled and the holding register is empty, so that an interrupt-driven driver is fed one byte at a time. When the channel is disabled, data writes are discarded. A write to a full holding register replaces the pending byte. Disabling the channel in the middle of a frame cuts that frame short.

Top module: `uart_tx_buf`

## Requirements
- R1: After reset `txd` is 1, `irq` is 0, the control register reads 0x00 and the status register reads 0x06.
- R2: Each frame drives a 0 start bit, then data bits 0 through 7 in that order, then a 1 stop bit. Between frames `txd` is 1.
- R3: With control bit 1 set, a parity bit goes between the data and the stop bit. Control bit 0 clear gives even parity (data XOR). Control bit 0 set gives odd parity (inverted XOR). With bit 1 clear, no parity bit is sent.
- R4: Each bit lasts K+1 clock cycles, where K is the value last written to address 3. A new K takes effect at the next bit boundary.
- R5: A write to the data register (address 0) while control bit 7 (enable) is 0 is discarded. Nothing is sent and the holding register stays empty.
- R6: A data write while status bit 2 is 0 (holding register full) replaces the pending byte. The replaced byte is never sent.
- R7: A held byte moves into the idle shift register one cycle after it is written. Status bit 2 then reads 1, and the frame starts at that same edge.
- R8: Status bit 1 reads 1 only when the holding register is empty and no frame is being shifted. It reads 0 during a frame.
- R9: `irq` is 1 exactly when the channel is enabled and the holding register is empty.
- R10: Writing control bit 7 as 0 during a frame returns `txd` to 1 at the next edge and drops any pending byte. Status then reads 0x06.
- R11: Reads return control at address 1 (bit 7 enable, bit 1 parity enable, bit 0 odd select), status at address 2 (bits 2 and 1, others 0), and K at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address: 0 data, 1 control, 2 status, 3 bit-period constant |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| txd | output | 1 | Serial output, idles high |
| irq | output | 1 | Transmit interrupt request |

## Verification
The checker watches, on every cycle, the rules that are local in time. These are: the line stays idle while the channel is disabled, a discarded write leaves the holding register empty, a pending byte loads into a free shifter, a frame opens with a low start bit and closes on a high stop bit, and the interrupt request appears only while the channel is enabled. The bench's scenarios cover the rest. They check the full serialized frame content and parity for each setting, bit timing under two constants, the replacement of a pending byte, the complete flag during and after a frame, and a frame cut short with its pending byte lost.

// File: rtl/uart_tx_buf.sv
module uart_tx_buf #(
  parameter int BAUD_W  = 8,
  parameter int DATA_W  = 8,
  localparam int FRAME_W = DATA_W + 3,
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic             txd,
  output logic             irq
);
  logic              tx_en, par_en, par_odd;
  logic [BAUD_W-1:0] baud_k, cnt;
  logic [DATA_W-1:0] hold_q;
  logic              hold_full, busy;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]  bits_left;

  wire wr_data = bus_wr && bus_addr == 2'd0;
  wire wr_ctrl = bus_wr && bus_addr == 2'd1;
  wire wr_baud = bus_wr && bus_addr == 2'd3;
  wire kill    = wr_ctrl && !bus_wdata[7];
  wire load    = tx_en && hold_full && !busy;
  wire tick    = busy && cnt == '0;
  wire par_bit = (^hold_q) ^ par_odd;

  wire [FRAME_W-1:0] frame = par_en ? {1'b1, par_bit, hold_q, 1'b0}
                                    : {2'b11, hold_q, 1'b0};
  wire [CNT_W-1:0] frame_len = par_en ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);

  assign txd = busy ? shreg[0] : 1'b1;
  assign irq = tx_en && !hold_full;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd1: begin
        bus_rdata[7] = tx_en;
        bus_rdata[1] = par_en;
        bus_rdata[0] = par_odd;
      end
      2'd2: begin
        bus_rdata[2] = !hold_full;
        bus_rdata[1] = !hold_full && !busy;
      end
      2'd3: bus_rdata = DATA_W'(baud_k);
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_en   <= 1'b0;
      par_en  <= 1'b0;
      par_odd <= 1'b0;
      baud_k  <= '0;
    end else begin
      if (wr_ctrl) begin
        tx_en   <= bus_wdata[7];
        par_en  <= bus_wdata[1];
        par_odd <= bus_wdata[0];
      end
      if (wr_baud) baud_k <= BAUD_W'(bus_wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
    end else if (kill) begin
      hold_full <= 1'b0;
    end else if (wr_data && tx_en) begin
      hold_q    <= bus_wdata;
      hold_full <= 1'b1;
    end else if (load) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      shreg     <= '1;
      bits_left <= '0;
      cnt       <= '0;
    end else if (kill) begin
      busy <= 1'b0;
    end else if (load) begin
      busy      <= 1'b1;
      shreg     <= frame;
      bits_left <= frame_len;
      cnt       <= baud_k;
    end else if (tick) begin
      cnt       <= baud_k;
      shreg     <= {1'b1, shreg[FRAME_W-1:1]};
      bits_left <= bits_left - 1'b1;
      if (bits_left == CNT_W'(1)) busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

module uart_tx_buf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bus_addr,
  input logic       bus_wr,
  input logic       txd,
  input logic       irq,
  input logic       tx_en,
  input logic       hold_full,
  input logic       busy
);
  p_idle_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> txd);
  p_drop_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && bus_wr && bus_addr == 2'd0) |=> !hold_full);
  p_auto_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && hold_full && !busy && !(bus_wr && bus_addr == 2'd1)) |=> busy);
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  p_stop_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && tx_en) |-> $past(txd));
  p_irq_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (tx_en && !hold_full));
endmodule

bind uart_tx_buf uart_tx_buf_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .txd(txd), .irq(irq), .tx_en(tx_en), .hold_full(hold_full), .busy(busy)
);

// File: tb/test_uart_tx_buf.sv
module test_uart_tx_buf;
  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic txd, irq;
  int total = 0, bad = 0, cycles = 0;

  always #4 clk = ~clk;

  uart_tx_buf i_uart_tx_buf (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .txd(txd), .irq(irq));

  // {parity enable, odd select, data}
  localparam logic [9:0] VEC [6] = '{
    {2'b00, 8'hA5}, {2'b00, 8'h01}, {2'b10, 8'h3C},
    {2'b10, 8'h07}, {2'b11, 8'hF0}, {2'b11, 8'h6B}};

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic get_frame(input int p, input int n, output logic [10:0] bits, output bit seen);
    int w = 0;
    bits = '1; seen = 0;
    while (txd !== 1'b0 && w < 400) begin @(negedge clk); w++; end
    if (txd !== 1'b0) return;
    seen = 1;
    repeat (p / 2) @(negedge clk);
    bits[0] = txd;
    for (int i = 1; i < n; i++) begin
      repeat (p) @(negedge clk);
      bits[i] = txd;
    end
  endtask

  function automatic logic [10:0] exp_frame(input bit pe, input bit odd, input logic [7:0] d);
    return pe ? {1'b1, (^d) ^ odd, d, 1'b0} : {2'b11, 1'b1, d, 1'b0};
  endfunction

  initial begin
    logic [7:0] r;
    logic [10:0] f;
    bit seen;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(2'd1, r); chk(r == 8'h00, "R1 ctrl", r, 0);
    rd(2'd2, r); chk(r == 8'h06, "R1 status", r, 6);
    chk(txd === 1'b1 && irq === 1'b0, "R1 txd/irq", {txd, irq}, 2);
    // R11 baud readback
    wr(2'd3, 8'd7);
    rd(2'd3, r); chk(r == 8'd7, "R11 baud read", r, 7);
    // R9 irq once enabled
    wr(2'd1, 8'h80);
    chk(irq === 1'b1, "R9 irq on enable", irq, 1);
    rd(2'd1, r); chk(r == 8'h80, "R11 ctrl read", r, 8'h80);

    // Vector walk: R2, R3, R4
    foreach (VEC[i]) begin
      wr(2'd1, {1'b1, 5'b0, VEC[i][9], VEC[i][8]});
      wr(2'd0, VEC[i][7:0]);
      n = VEC[i][9] ? 11 : 10;
      get_frame(8, n, f, seen);
      chk(seen && f == exp_frame(VEC[i][9], VEC[i][8], VEC[i][7:0]),
          "R2 R3 R4 frame", f, exp_frame(VEC[i][9], VEC[i][8], VEC[i][7:0]));
      repeat (8) @(negedge clk);
    end

    // R7, R8, R9 load and status timing
    wr(2'd1, 8'h80);
    wr(2'd0, 8'h5A);
    rd(2'd2, r); chk(r == 8'h04, "R7 R8 status during frame", r, 4);
    chk(irq === 1'b1, "R9 irq after load", irq, 1);
    get_frame(8, 10, f, seen);
    chk(seen && f == exp_frame(0, 0, 8'h5A), "R7 auto load frame", f, exp_frame(0, 0, 8'h5A));
    repeat (8) @(negedge clk);
    rd(2'd2, r); chk(r == 8'h06, "R8 complete after frame", r, 6);

    // R4 shorter bit period
    wr(2'd3, 8'd3);
    repeat (2) @(negedge clk);
    wr(2'd0, 8'hC3);
    get_frame(4, 10, f, seen);
    chk(seen && f == exp_frame(0, 0, 8'hC3), "R4 period 4", f, exp_frame(0, 0, 8'hC3));
    repeat (6) @(negedge clk);
    wr(2'd3, 8'd7);
    repeat (2) @(negedge clk);

    // R6 overwrite of pending byte
    wr(2'd0, 8'h11);
    fork
      get_frame(8, 10, f, seen);
      begin
        repeat (3) @(negedge clk);
        wr(2'd0, 8'h22);
        rd(2'd2, r); chk(r == 8'h00, "R6 holding full status", r, 0);
        chk(irq === 1'b0, "R9 irq low while full", irq, 0);
        wr(2'd0, 8'h33);
      end
    join
    chk(seen && f == exp_frame(0, 0, 8'h11), "R6 first frame", f, exp_frame(0, 0, 8'h11));
    get_frame(8, 10, f, seen);
    chk(seen && f == exp_frame(0, 0, 8'h33), "R6 replacing byte sent", f, exp_frame(0, 0, 8'h33));
    repeat (8) @(negedge clk);
    get_frame(8, 10, f, seen);
    chk(!seen, "R6 replaced byte not sent", seen, 0);

    // R5 write while disabled
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h99);
    rd(2'd2, r); chk(r == 8'h06, "R5 holding stays empty", r, 6);
    wr(2'd1, 8'h80);
    get_frame(8, 10, f, seen);
    chk(!seen, "R5 dropped byte not sent", seen, 0);

    // R10 disable mid-frame
    wr(2'd0, 8'h0F);
    wr(2'd0, 8'hE1);
    repeat (20) @(negedge clk);
    @(negedge clk); bus_addr = 2'd1; bus_wdata = 8'h00; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    chk(txd === 1'b1 && irq === 1'b0, "R10 line idle after disable", {txd, irq}, 2);
    rd(2'd2, r); chk(r == 8'h06, "R10 status after disable", r, 6);
    wr(2'd1, 8'h80);
    get_frame(8, 10, f, seen);
    chk(!seen, "R10 pending byte dropped", seen, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule